// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a stereo PCM stream on a three-wire serial port into parallel samples. The port has a bit clock, a frame clock and a data line. The block is always the slave on that port. Both serial clocks come in from outside and may have no phase or frequency relation to the system clock. All three serial wires pass through synchronisers, and the rising edges of the bit clock are found in the system clock domain. For this to work, the system clock must run at least four times faster than the bit clock.

Two static inputs set the framing and the word length. A single shift engine serves the left-justified, I2S and right-justified formats, for words of 16, 20, 24 or 32 bits. The frame clock may have any duty cycle, provided each half-frame carries enough bit clocks for its word. Each received word is sign-extended to 32 bits. When a full left/right pair has been received, both words appear on the outputs together with a one-cycle valid strobe. A flag beside the strobe marks a frame in which a half-frame was too short.

Top module: `ser_audio_rx`

## Requirements
- R1: While `rst_n` is low, both sample outputs read zero and `valid_o` and `err_o` are low.
- R2: Format code 0 (left-justified, with code 3 treated the same) works as follows. A low frame clock marks the left channel and a high frame clock marks the right channel. The MSB is sampled at the first bit-clock rising edge that sees the new frame-clock level, and the rest of the word follows MSB first.
- R3: Format code 2 (I2S) places the MSB on the second bit-clock rising edge after the frame-clock change. When the word fills its half-frame, the LSB falls on the first edge of the following half-frame.
- R4: Format code 1 (right-justified) takes the word from the final N bit-clock rising edges before the next frame-clock change. Earlier bits in that half-frame are ignored.
- R5: The word length code gives N as follows: 0 gives 16 bits, 1 gives 20, 2 gives 24 and 3 gives 32. In the left-justified and I2S formats, bits after the N-th are ignored.
- R6: Every received word appears sign-extended to 32 bits. Output bits 31 down to N all equal bit N-1.
- R7: `valid_o` is high for exactly one system clock cycle, and `left_o` and `right_o` change in that same cycle. The pulse comes three system clock cycles after the bit-clock rising edge at which the next left half-frame is recognised. That edge is the first one for left-justified and right-justified, and the second one for I2S.
- R8: The two halves of a frame may have different lengths, each up to 63 bit clocks. The words are still received correctly as long as each half holds at least N bit clocks.
- R9: When either half of a delivered frame held fewer than N bit clocks, `err_o` is high in the `valid_o` cycle. `err_o` is never high without `valid_o`.
- R10: `left_o` and `right_o` hold their values in every cycle without `valid_o`.
- R11: A half-frame already in progress when reset is released is never reported. The first strobe belongs to the first left half-frame that starts after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_clk_i | input | 1 | Serial bit clock, asynchronous |
| frame_clk_i | input | 1 | Frame clock: low means left, high means right |
| data_i | input | 1 | Serial data, sampled on the bit-clock rising edge |
| fmt_i | input | 2 | Framing: 0 left-justified, 1 right-justified, 2 I2S, 3 same as 0 |
| wlen_i | input | 2 | Word length: 0/1/2/3 select 16/20/24/32 bits |
| left_o | output | 32 | Left sample, sign-extended |
| right_o | output | 32 | Right sample, sign-extended |
| valid_o | output | 1 | One-cycle strobe when a new pair is present |
| err_o | output | 1 | Short half-frame in the delivered pair |

## Verification
Symmetric 32+32 frames are sent in all three formats. These separate the three alignment rules, because each format picks a different window out of the same 32 slots. The filler bits around the word alternate, so a window that is off by one slot gives a wrong value. Uneven frames (26+38, 24+40, 18+46) show that the left-justified and I2S formats stop capturing after N bits while the right-justified format keeps only the tail. Frames with negative and positive extremes exercise the sign extension. Short halves on the left or the right side must raise the error flag, and a following clean frame must clear it. The strobe timing is checked in every cycle, which also shows that the partial lead-in after reset is never delivered.

// File: rtl/ser_audio_rx_pkg.sv
package ser_audio_rx_pkg;

  localparam int unsigned SAMPLE_W = 32;
  localparam int unsigned IDX_W    = $clog2(SAMPLE_W);
  localparam int unsigned CNT_W    = IDX_W + 1;

  typedef enum logic [1:0] {
    FMT_LJ   = 2'd0,
    FMT_RJ   = 2'd1,
    FMT_I2S  = 2'd2,
    FMT_ALT  = 2'd3
  } fmt_e;

  function automatic logic [CNT_W-1:0] wlen_bits(input logic [1:0] code);
    case (code)
      2'd0:    return CNT_W'(16);
      2'd1:    return CNT_W'(20);
      2'd2:    return CNT_W'(24);
      default: return CNT_W'(32);
    endcase
  endfunction

endpackage

// File: rtl/ser_audio_sync.sv
module ser_audio_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int unsigned DEPTH = (STAGES < 2) ? 2 : STAGES;

  logic [DEPTH-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[DEPTH-2:0], d_i};
  end

  assign q_o = chain_q[DEPTH-1];
endmodule

// File: rtl/ser_audio_edge.sv
module ser_audio_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level_i;
  end

  assign rise_o = level_i & ~prev_q;
endmodule

// File: rtl/ser_audio_shift.sv
module ser_audio_shift
  import ser_audio_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_i,
  input  logic                lr_i,
  input  logic                bit_i,
  input  fmt_e                fmt_i,
  input  logic [1:0]          wlen_i,
  output logic                done_o,
  output logic                done_right_o,
  output logic                short_o,
  output logic [SAMPLE_W-1:0] word_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [1:0]       WARM    = 2'd2;

  logic [SAMPLE_W-1:0] sh_q, sh_d, base;
  logic [CNT_W-1:0]    cnt_q, cnt_d, idx, nbits;
  logic [IDX_W-1:0]    msb_idx;
  logic [1:0]          warm_q, warm_d;
  logic                lr_d1_q, lr_d1_d, lr_prev_q, lr_prev_d, lr_eff;
  logic                primed_q, primed_d, ready, bnd, shen;

  // I2S: the frame clock delayed by one bit clock marks the word boundary
  always_comb begin
    nbits  = wlen_bits(wlen_i);
    lr_eff = (fmt_i == FMT_I2S) ? lr_d1_q : lr_i;
    ready  = (warm_q == WARM);
    bnd    = tick_i && ready && (lr_eff != lr_prev_q);
    idx    = bnd ? '0 : cnt_q;
    shen   = (fmt_i == FMT_RJ) || (idx < nbits);
    base   = bnd ? '0 : sh_q;

    sh_d      = sh_q;
    cnt_d     = cnt_q;
    lr_d1_d   = lr_d1_q;
    lr_prev_d = lr_prev_q;
    warm_d    = warm_q;
    primed_d  = primed_q | bnd;
    if (tick_i) begin
      sh_d      = shen ? {base[SAMPLE_W-2:0], bit_i} : base;
      cnt_d     = bnd ? CNT_W'(1) : ((cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_W'(1));
      lr_d1_d   = lr_i;
      lr_prev_d = lr_eff;
      if (!ready) warm_d = warm_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q      <= '0;
      cnt_q     <= '0;
      lr_d1_q   <= 1'b0;
      lr_prev_q <= 1'b0;
      warm_q    <= '0;
      primed_q  <= 1'b0;
    end else begin
      sh_q      <= sh_d;
      cnt_q     <= cnt_d;
      lr_d1_q   <= lr_d1_d;
      lr_prev_q <= lr_prev_d;
      warm_q    <= warm_d;
      primed_q  <= primed_d;
    end
  end

  assign done_o       = bnd && primed_q;
  assign done_right_o = lr_prev_q;
  assign short_o      = (cnt_q < nbits);
  assign msb_idx      = IDX_W'(nbits - CNT_W'(1));

  always_comb begin
    for (int i = 0; i < SAMPLE_W; i++)
      word_o[i] = (i < int'(nbits)) ? sh_q[i] : sh_q[msb_idx];
  end
endmodule

// File: rtl/ser_audio_rx.sv
module ser_audio_rx
  import ser_audio_rx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bit_clk_i,
  input  logic        frame_clk_i,
  input  logic        data_i,
  input  logic [1:0]  fmt_i,
  input  logic [1:0]  wlen_i,
  output logic [31:0] left_o,
  output logic [31:0] right_o,
  output logic        valid_o,
  output logic        err_o
);
  logic [1:0]          rst_sync_q;
  logic                core_rst_n;
  logic [2:0]          pins_s;
  logic                tick, done, done_right, short_half;
  logic [SAMPLE_W-1:0] word;

  logic [SAMPLE_W-1:0] left_hold_q, left_hold_d, left_q, left_d, right_q, right_d;
  logic                lshort_q, lshort_d, have_left_q, have_left_d;
  logic                valid_q, valid_d, err_q, err_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  ser_audio_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (core_rst_n),
    .d_i   ({frame_clk_i, data_i, bit_clk_i}),
    .q_o   (pins_s)
  );

  ser_audio_edge u_edge (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .level_i (pins_s[0]),
    .rise_o  (tick)
  );

  ser_audio_shift u_shift (
    .clk          (clk),
    .rst_n        (core_rst_n),
    .tick_i       (tick),
    .lr_i         (pins_s[2]),
    .bit_i        (pins_s[1]),
    .fmt_i        (fmt_e'(fmt_i)),
    .wlen_i       (wlen_i),
    .done_o       (done),
    .done_right_o (done_right),
    .short_o      (short_half),
    .word_o       (word)
  );

  always_comb begin
    left_hold_d = left_hold_q;
    lshort_d    = lshort_q;
    have_left_d = have_left_q;
    left_d      = left_q;
    right_d     = right_q;
    valid_d     = 1'b0;
    err_d       = 1'b0;
    if (done) begin
      if (!done_right) begin
        left_hold_d = word;
        lshort_d    = short_half;
        have_left_d = 1'b1;
      end else begin
        if (have_left_q) begin
          left_d  = left_hold_q;
          right_d = word;
          valid_d = 1'b1;
          err_d   = lshort_q | short_half;
        end
        have_left_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      left_hold_q <= '0;
      lshort_q    <= 1'b0;
      have_left_q <= 1'b0;
      left_q      <= '0;
      right_q     <= '0;
      valid_q     <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      left_hold_q <= left_hold_d;
      lshort_q    <= lshort_d;
      have_left_q <= have_left_d;
      left_q      <= left_d;
      right_q     <= right_d;
      valid_q     <= valid_d;
      err_q       <= err_d;
    end
  end

  assign left_o  = left_q;
  assign right_o = right_q;
  assign valid_o = valid_q;
  assign err_o   = err_q;
endmodule

// File: rtl/ser_audio_rx_chk.sv
module ser_audio_rx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  wlen_i,
  input logic [31:0] left_o,
  input logic [31:0] right_o,
  input logic        valid_o,
  input logic        err_o
);
  function automatic logic ext_ok(input logic [31:0] v, input logic [1:0] w);
    case (w)
      2'd0:    return v[31:15] == {17{v[15]}};
      2'd1:    return v[31:19] == {13{v[19]}};
      2'd2:    return v[31:23] == {9{v[23]}};
      default: return 1'b1;
    endcase
  endfunction

  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  // R9
  err_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> valid_o);

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> ($stable(left_o) && $stable(right_o)));

  // R6
  sign_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (ext_ok(left_o, wlen_i) && ext_ok(right_o, wlen_i)));
endmodule

bind ser_audio_rx ser_audio_rx_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wlen_i  (wlen_i),
  .left_o  (left_o),
  .right_o (right_o),
  .valid_o (valid_o),
  .err_o   (err_o)
);

// File: tb/ser_audio_rx_bench.sv
module ser_audio_rx_bench;
  logic        clk = 1'b0;
  logic        rst_n, bit_clk, frame_clk, data;
  logic [1:0]  fmt, wlen;
  logic [31:0] left_o, right_o;
  logic        valid_o, err_o;

  always #2 clk = ~clk;

  ser_audio_rx u_ser_audio_rx (
    .clk(clk), .rst_n(rst_n), .bit_clk_i(bit_clk), .frame_clk_i(frame_clk),
    .data_i(data), .fmt_i(fmt), .wlen_i(wlen), .left_o(left_o),
    .right_o(right_o), .valid_o(valid_o), .err_o(err_o)
  );

  int cyc = 0, errors = 0, checks = 0, nbits = 16;
  bit chk_on = 0, finished = 0;
  int          exp_due[$];
  logic [31:0] exp_l[$], exp_r[$];
  logic        exp_e[$];
  string       exp_tag[$];
  logic        carry, pend_v, pend_e;
  logic [31:0] pend_l, pend_r, last_l, last_r;
  string       cur_tag;

  always @(posedge clk) cyc++;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h cycle=%0d", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [31:0] sx(input logic [31:0] w);
    int s = 32 - nbits;
    return $signed(w << s) >>> s;
  endfunction

  // Reference model: expected strobes queued per frame, compared every cycle
  always @(negedge clk) if (chk_on) begin
    if (exp_due.size() > 0 && exp_due[0] == cyc) begin
      check({exp_tag[0], " R7 valid_o strobe"}, {31'b0, valid_o}, 32'd1);
      check({exp_tag[0], " R9 err_o"}, {31'b0, err_o}, {31'b0, exp_e[0]});
      if (!exp_e[0]) begin
        check({exp_tag[0], " R6 left_o"}, left_o, exp_l[0]);
        check({exp_tag[0], " R6 right_o"}, right_o, exp_r[0]);
      end
      last_l = left_o;
      last_r = right_o;
      void'(exp_due.pop_front()); void'(exp_l.pop_front());
      void'(exp_r.pop_front()); void'(exp_e.pop_front()); void'(exp_tag.pop_front());
    end else begin
      check("R7 R11 valid_o idle", {31'b0, valid_o}, 32'd0);
      check("R9 err_o idle", {31'b0, err_o}, 32'd0);
      check("R10 left_o hold", left_o, last_l);
      check("R10 right_o hold", right_o, last_r);
    end
  end

  task automatic slot(input logic lr, input logic d, input bit mark);
    bit_clk = 1'b0; frame_clk = lr; data = d;
    repeat (4) @(negedge clk);
    bit_clk = 1'b1;
    if (mark && pend_v) begin
      exp_due.push_back(cyc + 3);
      exp_l.push_back(pend_l); exp_r.push_back(pend_r);
      exp_e.push_back(pend_e); exp_tag.push_back(cur_tag);
      pend_v = 1'b0;
    end
    repeat (4) @(negedge clk);
  endtask

  function automatic logic gen_bit(input int n, input int i, input logic [31:0] w);
    int k;
    if (fmt == 2'd2 && i == 0) return carry;
    if (fmt == 2'd1)      k = i - (n - nbits);
    else if (fmt == 2'd2) k = i - 1;
    else                  k = i;
    if (k >= 0 && k < nbits) return w[nbits-1-k];
    return i[0];
  endfunction

  task automatic half(input logic lr, input int n, input logic [31:0] w);
    int mk = (fmt == 2'd2) ? 1 : 0;
    for (int i = 0; i < n; i++) slot(lr, gen_bit(n, i, w), (lr == 1'b0) && (i == mk));
    carry = (fmt == 2'd2 && n == nbits) ? w[0] : 1'b0;
  endtask

  task automatic frame(input logic [31:0] l, input logic [31:0] r, input int nl, input int nr);
    half(1'b0, nl, l);
    half(1'b1, nr, r);
    pend_l = sx(l); pend_r = sx(r);
    pend_e = (nl < nbits) || (nr < nbits);
    pend_v = 1'b1;
  endtask

  task automatic restart(input logic [1:0] f, input logic [1:0] w, input string tag);
    @(posedge clk); #1;
    chk_on = 0; rst_n = 1'b0;
    bit_clk = 1'b0; frame_clk = 1'b1; data = 1'b0;
    fmt = f; wlen = w;
    case (w) 2'd0: nbits = 16; 2'd1: nbits = 20; 2'd2: nbits = 24; default: nbits = 32; endcase
    pend_v = 0; carry = 0; cur_tag = tag; last_l = '0; last_r = '0;
    @(negedge clk);
    check("R1 reset left_o", left_o, 32'd0);
    check("R1 reset right_o", right_o, 32'd0);
    check("R1 reset valid_o", {31'b0, valid_o}, 32'd0);
    check("R1 reset err_o", {31'b0, err_o}, 32'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1 chk_on = 1;
    @(negedge clk);
    repeat (3) @(negedge clk);
    for (int i = 0; i < 3; i++) slot(1'b1, 1'b1, 1'b0);   // R11 partial lead-in
  endtask

  initial begin
    rst_n = 1'b0; bit_clk = 0; frame_clk = 1; data = 0; fmt = 0; wlen = 0;
    restart(2'd0, 2'd0, "R2 R5 lj16");
    frame(32'h8001, 32'h7FFF, 32, 32);
    frame(32'h1234, 32'hFEDC, 32, 32);
    frame(32'hFFFF, 32'h0000, 32, 32);
    half(1'b0, 4, 0);

    restart(2'd0, 2'd2, "R2 R8 lj24");
    frame(32'h800000, 32'h123456, 32, 32);
    frame(32'h7ABCDE, 32'hF00001, 26, 38);
    half(1'b0, 4, 0);

    restart(2'd2, 2'd3, "R3 i2s32");
    frame(32'h8000_0001, 32'h7FFF_FFFE, 32, 32);
    frame(32'hDEAD_BEEF, 32'h0123_4567, 32, 32);
    half(1'b0, 4, 0);

    restart(2'd2, 2'd1, "R3 R8 i2s20");
    frame(32'h80001, 32'h7FFFF, 24, 40);
    half(1'b0, 4, 0);

    restart(2'd1, 2'd0, "R4 R8 rj16");
    frame(32'hC3A5, 32'h0F0F, 32, 32);
    frame(32'h8000, 32'h0001, 18, 46);
    half(1'b0, 4, 0);

    restart(2'd1, 2'd1, "R4 R5 rj20");
    frame(32'hA5A5A, 32'h5A5A5, 32, 32);
    half(1'b0, 4, 0);

    restart(2'd0, 2'd0, "R9 lj16 short left");
    frame(32'h1111, 32'h2222, 12, 52);
    frame(32'h3333, 32'hC444, 32, 32);
    half(1'b0, 4, 0);

    restart(2'd1, 2'd2, "R9 rj24 short right");
    frame(32'h123456, 32'h654321, 44, 20);
    half(1'b0, 4, 0);

    restart(2'd3, 2'd1, "R2 R5 code3");
    frame(32'h8ACE1, 32'h13579, 32, 32);
    half(1'b0, 4, 0);

    repeat (10) @(negedge clk);
    check("R7 all strobes seen", exp_due.size(), 32'd0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL R7 watchdog actual=hung expected=finish cycle=%0d", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule